// File: doc/BRIEF.md
# Horizontal Character-Clock Timing Generator

This block steps a scan-line counter once per character clock and derives the horizontal display window, the horizontal blanking interval and the horizontal sync pulse from a set of programmed values. The line length, the end of the active area and the start positions of blanking and sync are compared against the full counter width. The ends of blanking and sync are found by matching only the low bits of the counter against short end codes. This keeps those comparators narrow and lets either interval run across the end of a line.

The character clock is an enable (`chr_en`) on the block clock, and the counter and all state move only on cycles where it is high. The display window can be delayed by zero to three character clocks. The sync start can be pushed later by a skew of zero to three. A one-tick end-of-line flag is provided for the vertical timing logic. A sync gate forces the sync output low without touching any internal state.

Top module: `hts_htiming`

## Requirements
- R1: The counter runs 0, 1, … up to `total_i + 5 - 1` and then returns to 0, so one line lasts `total_i + 5` character clocks. It advances only on cycles with `chr_en` high.
- R2: `line_end_o` is high for exactly the character-clock period that follows a wrap to 0. While it is high the counter reads 0.
- R3: With a display skew of 0, `disp_en_o` is high exactly while the counter is less than or equal to `disp_end_i`.
- R4: With a display skew of k (1 to 3), `disp_en_o` equals the undelayed window value from k character clocks earlier.
- R5: `hblank_o` rises when the counter advances to `blank_start_i`. It falls when the counter advances to a value whose low 6 bits equal `blank_end_i`. A match on the start tick itself does not end it, so blanking lasts from 1 to 64 character clocks.
- R6: Blanking that is still active at the wrap continues into the next line and ends at the first low-6-bit match there.
- R7: A blank start or sync start beyond the last count of the line never produces blanking or sync.
- R8: `hsync_o` rises when the counter advances to `sync_start_i + sync_skew_i`.
- R9: `hsync_o` falls when the counter advances to a value whose low 5 bits equal `sync_end_i`. A match on the start tick does not end it, so sync lasts from 1 to 32 character clocks.
- R10: With `sync_on_i` low, `hsync_o` is 0 while the internal sync state keeps running. Raising `sync_on_i` again shows the sync that the timing dictates at that moment.
- R11: During reset the counter is 0 and `hblank_o`, `hsync_o` and `line_end_o` are 0. The blank and sync states then start inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chr_en | input | 1 | Character-clock enable |
| total_i | input | RW | Line length minus 5 |
| disp_end_i | input | RW | Last count of the active area |
| blank_start_i | input | RW | Count at which blanking begins |
| blank_end_i | input | BEW | Low-bit code that ends blanking |
| sync_start_i | input | RW | Count at which sync begins, before skew |
| sync_end_i | input | SEW | Low-bit code that ends sync |
| de_skew_i | input | SKW | Display-window delay in character clocks |
| sync_skew_i | input | SKW | Added to the sync start |
| sync_on_i | input | 1 | Sync output gate |
| count_o | output | CW | Current character count |
| disp_en_o | output | 1 | Display enable after skew |
| hblank_o | output | 1 | Horizontal blanking |
| hsync_o | output | 1 | Horizontal sync, active high |
| line_end_o | output | 1 | One-tick flag after wrap |

## Verification
The bench builds the block with its default parameters: 8-bit register fields, a 9-bit counter, an offset of 5, a 6-bit blank-end code, a 5-bit sync-end code and skews up to 3. With these values a line can reach its longest length of 260 clocks, so the counter's ninth bit is exercised. Every tap of the display delay line is selectable. Both end codes can produce their full 64- and 32-clock windows, including windows that cross the wrap.

// File: rtl/hts_pkg.sv
package hts_pkg;
   // default geometry of the block
   localparam int HTS_REG_W    = 8;
   localparam int HTS_CNT_W    = 9;
   localparam int HTS_EXTRA    = 5;
   localparam int HTS_BEND_W   = 6;
   localparam int HTS_SEND_W   = 5;
   localparam int HTS_MAX_SKEW = 3;

   function automatic int hts_sel_w(input int max_skew);
      return (max_skew < 1) ? 1 : $clog2(max_skew + 1);
   endfunction
endpackage

// File: rtl/hts_counter.sv
module hts_counter #(
   parameter int CW    = 9,
   parameter int RW    = 8,
   parameter int EXTRA = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [RW-1:0] total,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] nxt_o,
   output logic          line_end_o
);
   localparam int PADW = CW - RW;
   localparam logic [CW-1:0] TAIL = CW'(EXTRA - 1);

   logic [CW-1:0] last_cnt;
   logic          wrap;
   logic [CW-1:0] cnt_q;
   logic          le_q;

   assign last_cnt = {{PADW{1'b0}}, total} + TAIL;
   assign wrap     = (cnt_q == last_cnt);
   assign nxt_o    = wrap ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         le_q  <= 1'b0;
      end else if (adv) begin
         cnt_q <= nxt_o;
         le_q  <= wrap;
      end
   end

   assign cnt_o      = cnt_q;
   assign line_end_o = le_q;
endmodule

// File: rtl/hts_window.sv
module hts_window #(
   parameter int CW = 9,
   parameter int MW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [CW-1:0] nxt,
   input  logic [CW-1:0] start,
   input  logic [MW-1:0] stop,
   output logic          active_o
);
   logic act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
      end else if (adv) begin
         if (!act_q && (nxt == start)) begin
            act_q <= 1'b1;
         end else if (act_q && (nxt[MW-1:0] == stop)) begin
            act_q <= 1'b0;
         end
      end
   end

   assign active_o = act_q;
endmodule

// File: rtl/hts_skew.sv
module hts_skew #(
   parameter int MAX_SKEW = 3,
   parameter int SKW      = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic           din,
   input  logic [SKW-1:0] sel,
   output logic           dout
);
   generate
      if (MAX_SKEW == 0) begin : g_direct
         assign dout = din;
      end else begin : g_pipe
         logic [MAX_SKEW:1] pipe_q;
         logic [MAX_SKEW:0] taps;

         assign taps = {pipe_q, din};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else if (adv) begin
               pipe_q <= taps[MAX_SKEW-1:0];
            end
         end

         assign dout = (int'(sel) > MAX_SKEW) ? taps[MAX_SKEW] : taps[sel];
      end
   endgenerate
endmodule

// File: rtl/hts_htiming.sv
module hts_htiming
   import hts_pkg::*;
#(
   parameter int RW       = HTS_REG_W,
   parameter int CW       = HTS_CNT_W,
   parameter int EXTRA    = HTS_EXTRA,
   parameter int BEW      = HTS_BEND_W,
   parameter int SEW      = HTS_SEND_W,
   parameter int MAX_SKEW = HTS_MAX_SKEW,
   parameter int SKW      = hts_sel_w(HTS_MAX_SKEW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           chr_en,
   input  logic [RW-1:0]  total_i,
   input  logic [RW-1:0]  disp_end_i,
   input  logic [RW-1:0]  blank_start_i,
   input  logic [BEW-1:0] blank_end_i,
   input  logic [RW-1:0]  sync_start_i,
   input  logic [SEW-1:0] sync_end_i,
   input  logic [SKW-1:0] de_skew_i,
   input  logic [SKW-1:0] sync_skew_i,
   input  logic           sync_on_i,
   output logic [CW-1:0]  count_o,
   output logic           disp_en_o,
   output logic           hblank_o,
   output logic           hsync_o,
   output logic           line_end_o
);
   localparam int PADW = CW - RW;

   // elaboration-time parameter checks
   generate
      if ((2 ** CW) < (2 ** RW + EXTRA - 1)) begin : g_bad_cw
         $error("hts_htiming: CW too narrow for longest line");
      end
      if (CW <= RW) begin : g_bad_pad
         $error("hts_htiming: CW must exceed RW");
      end
      if (EXTRA < 1) begin : g_bad_extra
         $error("hts_htiming: EXTRA must be at least 1");
      end
      if ((BEW > CW) || (SEW > CW) || (BEW < 1) || (SEW < 1)) begin : g_bad_match
         $error("hts_htiming: end-code widths out of range");
      end
      if ((MAX_SKEW < 0) || (SKW < hts_sel_w(MAX_SKEW)) || (SKW > CW)) begin : g_bad_skew
         $error("hts_htiming: skew select width inconsistent");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] nxt;
   logic [CW-1:0] blank_at;
   logic [CW-1:0] sync_at;
   logic          de_raw;
   logic          sync_state;

   hts_counter #(.CW(CW), .RW(RW), .EXTRA(EXTRA)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (chr_en),
      .total      (total_i),
      .cnt_o      (cnt),
      .nxt_o      (nxt),
      .line_end_o (line_end_o)
   );

   assign de_raw = (cnt <= {{PADW{1'b0}}, disp_end_i});

   hts_skew #(.MAX_SKEW(MAX_SKEW), .SKW(SKW)) u_de_skew (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (chr_en),
      .din   (de_raw),
      .sel   (de_skew_i),
      .dout  (disp_en_o)
   );

   assign blank_at = {{PADW{1'b0}}, blank_start_i};
   assign sync_at  = {{PADW{1'b0}}, sync_start_i} + CW'(sync_skew_i);

   hts_window #(.CW(CW), .MW(BEW)) u_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (chr_en),
      .nxt      (nxt),
      .start    (blank_at),
      .stop     (blank_end_i),
      .active_o (hblank_o)
   );

   hts_window #(.CW(CW), .MW(SEW)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (chr_en),
      .nxt      (nxt),
      .start    (sync_at),
      .stop     (sync_end_i),
      .active_o (sync_state)
   );

   assign hsync_o = sync_state & sync_on_i;
   assign count_o = cnt;
endmodule

// File: rtl/hts_htiming_chk.sv
module hts_htiming_chk #(
   parameter int RW    = 8,
   parameter int CW    = 9,
   parameter int EXTRA = 5,
   parameter int BEW   = 6,
   parameter int SEW   = 5,
   parameter int SKW   = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           chr_en,
   input logic [RW-1:0]  total_i,
   input logic [RW-1:0]  disp_end_i,
   input logic [RW-1:0]  blank_start_i,
   input logic [BEW-1:0] blank_end_i,
   input logic [SEW-1:0] sync_end_i,
   input logic [SKW-1:0] de_skew_i,
   input logic           sync_on_i,
   input logic [CW-1:0]  count_o,
   input logic           disp_en_o,
   input logic           hblank_o,
   input logic           hsync_o,
   input logic           line_end_o
);
   localparam int PADW = CW - RW;

   logic [CW-1:0] ck_last;
   logic [CW-1:0] ck_next;

   assign ck_last = {{PADW{1'b0}}, total_i} + CW'(EXTRA - 1);
   assign ck_next = (count_o == ck_last) ? '0 : count_o + 1'b1;

   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_en && (count_o == ck_last)) |=> (count_o == '0));

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_en |=> $stable(count_o));

   assert_flag_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_end_o |-> (count_o == '0));

   assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (de_skew_i == '0) |-> (disp_en_o == (count_o <= {{PADW{1'b0}}, disp_end_i})));

   assert_blank_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_en && !hblank_o && (ck_next == {{PADW{1'b0}}, blank_start_i})) |=> hblank_o);

   assert_blank_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_en && hblank_o && (ck_next[BEW-1:0] == blank_end_i)) |=> !hblank_o);

   assert_sync_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_en && hsync_o && (ck_next[SEW-1:0] == sync_end_i)) |=> !hsync_o);

   assert_sync_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_on_i |-> !hsync_o);
endmodule

bind hts_htiming hts_htiming_chk #(
   .RW(RW), .CW(CW), .EXTRA(EXTRA), .BEW(BEW), .SEW(SEW), .SKW(SKW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .chr_en        (chr_en),
   .total_i       (total_i),
   .disp_end_i    (disp_end_i),
   .blank_start_i (blank_start_i),
   .blank_end_i   (blank_end_i),
   .sync_end_i    (sync_end_i),
   .de_skew_i     (de_skew_i),
   .sync_on_i     (sync_on_i),
   .count_o       (count_o),
   .disp_en_o     (disp_en_o),
   .hblank_o      (hblank_o),
   .hsync_o       (hsync_o),
   .line_end_o    (line_end_o)
);

// File: tb/hts_htiming_tb.sv
module hts_htiming_tb;
   localparam int CLK_P = 10;
   localparam int RW = 8;
   localparam int CW = 9;
   localparam int BEW = 6;
   localparam int SEW = 5;
   localparam int SKW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           chr_en = 1'b0;
   logic [RW-1:0]  total_i = '0;
   logic [RW-1:0]  disp_end_i = '0;
   logic [RW-1:0]  blank_start_i = '0;
   logic [BEW-1:0] blank_end_i = '0;
   logic [RW-1:0]  sync_start_i = '0;
   logic [SEW-1:0] sync_end_i = '0;
   logic [SKW-1:0] de_skew_i = '0;
   logic [SKW-1:0] sync_skew_i = '0;
   logic           sync_on_i = 1'b1;
   logic [CW-1:0]  count_o;
   logic           disp_en_o, hblank_o, hsync_o, line_end_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   int m_cnt;
   bit m_blank, m_sync, m_le;
   bit m_hist[1:3];

   always #(CLK_P/2) clk = ~clk;

   hts_htiming u_dut (
      .clk(clk), .rst_n(rst_n), .chr_en(chr_en),
      .total_i(total_i), .disp_end_i(disp_end_i),
      .blank_start_i(blank_start_i), .blank_end_i(blank_end_i),
      .sync_start_i(sync_start_i), .sync_end_i(sync_end_i),
      .de_skew_i(de_skew_i), .sync_skew_i(sync_skew_i), .sync_on_i(sync_on_i),
      .count_o(count_o), .disp_en_o(disp_en_o), .hblank_o(hblank_o),
      .hsync_o(hsync_o), .line_end_o(line_end_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int next_cnt(input int c);
      int last = int'(total_i) + 4;
      return (c == last) ? 0 : ((c + 1) % (1 << CW));
   endfunction

   function automatic bit raw_de(input int c);
      return c <= int'(disp_end_i);
   endfunction

   task automatic model_tick();
      int n = next_cnt(m_cnt);
      int sstart = (int'(sync_start_i) + int'(sync_skew_i)) % (1 << CW);
      m_hist[3] = m_hist[2];
      m_hist[2] = m_hist[1];
      m_hist[1] = raw_de(m_cnt);
      m_le = (m_cnt == int'(total_i) + 4);
      if (!m_blank && n == int'(blank_start_i)) m_blank = 1;
      else if (m_blank && (n % 64) == int'(blank_end_i)) m_blank = 0;
      if (!m_sync && n == sstart) m_sync = 1;
      else if (m_sync && (n % 32) == int'(sync_end_i)) m_sync = 0;
      m_cnt = n;
   endtask

   // bt: tag for blank checks, st: tag for sync checks
   // son_mode: 0 gate off, 1 gate on, 2 gate toggled; en_pct: enable percentage
   task automatic run_cfg(input string bt, input string st,
                          input int tot, input int de, input int bs, input int be,
                          input int ss, input int se, input int dsk, input int ssk,
                          input int son_mode, input int en_pct, input int ncyc);
      string dreq;
      string sreq;
      int exp_de;
      @(negedge clk);
      rst_n = 1'b0;
      chr_en = 1'b0;
      total_i = RW'(tot); disp_end_i = RW'(de);
      blank_start_i = RW'(bs); blank_end_i = BEW'(be);
      sync_start_i = RW'(ss); sync_end_i = SEW'(se);
      de_skew_i = SKW'(dsk); sync_skew_i = SKW'(ssk);
      sync_on_i = (son_mode != 0);
      repeat (2) @(negedge clk);
      // R11: reset state
      check("R11", "count", int'(count_o), 0);
      check("R11", "hblank", int'(hblank_o), 0);
      check("R11", "hsync", int'(hsync_o), 0);
      check("R11", "line_end", int'(line_end_o), 0);
      m_cnt = 0; m_blank = 0; m_sync = 0; m_le = 0;
      for (int k = 1; k <= 3; k++) m_hist[k] = 0;
      rst_n = 1'b1;
      dreq = (dsk == 0) ? "R3" : "R4";
      sreq = (son_mode == 1) ? st : "R10";
      for (int i = 0; i < ncyc; i++) begin
         chr_en = (int'($urandom_range(99)) < en_pct);
         if (son_mode == 2 && $urandom_range(15) == 0) sync_on_i = ~sync_on_i;
         @(posedge clk);
         if (chr_en) model_tick();
         @(negedge clk);
         exp_de = (dsk == 0) ? int'(raw_de(m_cnt)) : int'(m_hist[dsk]);
         check("R1", "count", int'(count_o), m_cnt);
         check("R2", "line_end", int'(line_end_o), int'(m_le));
         check(dreq, "disp_en", int'(disp_en_o), exp_de);
         check(bt, "hblank", int'(hblank_o), int'(m_blank));
         check(sreq, "hsync", int'(hsync_o), int'(m_sync && sync_on_i));
      end
   endtask

   initial begin
      void'($urandom(32'd7321));
      // R1 R2 R3 R5 R8 R9 base pattern, enable always high
      run_cfg("R5", "R8", 10, 7, 9, 12, 10, 13, 0, 0, 1, 100, 80);
      // R4: each display skew tap
      for (int k = 1; k <= 3; k++)
         run_cfg("R5", "R8", 12, 8, 10, 14, 11, 15, k, 0, 1, 80, 120);
      // R6: blanking that crosses the wrap
      run_cfg("R6", "R8", 10, 7, 13, 2, 11, 14, 0, 0, 1, 100, 80);
      // R5: 64-clock blanking when end code equals start's low bits
      run_cfg("R5", "R8", 100, 80, 20, 20, 85, 90, 0, 0, 1, 100, 260);
      // R7: starts beyond the last count
      run_cfg("R7", "R7", 10, 7, 20, 3, 30, 4, 0, 0, 1, 100, 80);
      // R9: 32-clock sync when end code equals start's low bits
      run_cfg("R5", "R9", 60, 40, 45, 50, 5, 5, 0, 0, 1, 100, 200);
      // R8: sync start shifted by skew
      run_cfg("R5", "R8", 20, 15, 16, 22, 17, 20, 0, 2, 1, 100, 100);
      // R10: gate off, then toggled
      run_cfg("R5", "R10", 20, 15, 16, 22, 17, 25, 0, 1, 0, 100, 100);
      run_cfg("R5", "R10", 30, 20, 22, 28, 23, 3, 1, 3, 2, 90, 300);
      // R1: longest line
      run_cfg("R5", "R8", 255, 200, 210, 8, 220, 4, 0, 0, 1, 100, 700);
      // random configurations
      for (int r = 0; r < 25; r++) begin
         int tot = int'($urandom_range(80));
         run_cfg("R5", "R8", tot, int'($urandom_range(tot + 6)),
                 int'($urandom_range(tot + 10)), int'($urandom_range(63)),
                 int'($urandom_range(tot + 10)), int'($urandom_range(31)),
                 int'($urandom_range(3)), int'($urandom_range(3)),
                 (r % 4 == 3) ? 2 : 1, 75, 400);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule